// File: doc/BRIEF.md
# Dual-Stack Forth Execution Core

This block is a 16-bit stack processor that executes Forth primitive words directly in hardware. The two topmost data-stack entries live in dedicated registers (top and second), which feed a small ALU. Deeper entries sit in a register-file stack. A separate return stack holds call return addresses and values moved with `>r`. Add and subtract share one adder: subtraction inverts the top operand and forces the carry-in, which yields second minus top.

Every non-control word finishes in one clock, and that includes the three-entry permutations. Jumps, conditional jumps, calls and returns take exactly two clocks. In the first clock the core decodes the word, applies its stack effect and latches the target. In the second clock it loads the program counter. The core fetches instructions through an asynchronous program port. It reads and writes data through an asynchronous data port. Both stacks are observable at the ports and carry sticky overflow and underflow flags.

Top module: `stk_core`

## Requirements
- R1: While `rstN` is low and right after it is released, `progAddr` is 0, both depths are 0, `tosOut` is 0, both flags are 0 and `dataWe` is 0.
- R2: Instruction encoding is as follows. Bit 15 set pushes the literal `{0, bits 14:0}`. Bits 15:12 = 0001 is a jump, 0010 is a pop-and-jump-if-zero, 0011 is a call and 0100 is a return, each with the target in bits 11:0. Bits 15:12 = 0000 selects a stack word by bits 4:0: 0 nop, 1 `+`, 2 `-`, 3 `2*`, 4 `2/`, 5 `not`, 6 `=`, 7 `dup`, 8 `drop`, 9 `swap`, 10 `over`, 11 `nip`, 12 `tuck`, 13 `rot`, 14 `-rot`, 15 `@`, 16 `!`, 17 `>r`, 18 `r>`. All other codes are nops.
- R3: `+` and `-` pop both operands and push second+top or second−top, modulo 2^16.
- R4: `2*` shifts the top left by one and fills with zero. `2/` shifts it right by one and keeps the sign bit. `not` inverts every bit. Depth is unchanged.
- R5: `=` pops both operands and pushes 16'hFFFF when they are equal and 16'h0000 otherwise.
- R6: With c on top, `rot` maps (a b c) to (b c a), `-rot` maps (a b c) to (c a b), and `tuck` maps (a b) to (b a b). Each completes in one clock.
- R7: `dup`, `drop`, `swap`, `over` and `nip` have their standard Forth stack effects.
- R8: `!` drives `dataWe` high with address = top and data = second, then pops both. `@` replaces the top with the read data at address = top.
- R9: `>r` moves the top to the return stack. `r>` moves the return-stack top back onto the data stack. Each takes one clock.
- R10: A jump leaves `progAddr` unchanged for one clock and then presents the target. A conditional jump pops the top and branches only when the popped value is zero; otherwise it continues at the next address.
- R11: A call pushes its own address + 1 onto the return stack and reaches the target after two clocks. A return pops that value into the program counter, also in two clocks.
- R12: A word that needs more entries than a stack holds sets the sticky underflow flag. A push onto a stack already holding 16 entries sets the sticky overflow flag. In both cases neither stack nor data memory changes. The flags clear only on reset.
- R13: Each non-control word advances `progAddr` by exactly one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progAddr | output | 12 | Program counter / instruction address |
| progData | input | 16 | Instruction word at `progAddr` (same-cycle) |
| dataAddr | output | 16 | Data memory address (top of stack) |
| dataWdata | output | 16 | Data memory write value (second entry) |
| dataWe | output | 1 | Data memory write strobe |
| dataRdata | input | 16 | Data memory read value at `dataAddr` (same-cycle) |
| tosOut | output | 16 | Top data-stack entry |
| nosOut | output | 16 | Second data-stack entry |
| rTopOut | output | 16 | Top return-stack entry (0 when empty) |
| dDepth | output | 5 | Data-stack entry count |
| rDepth | output | 5 | Return-stack entry count |
| ovfFlag | output | 1 | Sticky overflow flag |
| unfFlag | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that `progData` and `dataRdata` are settled combinational functions of the addresses the core presents, and that they hold no X while reset is released. The bench meets this with its own program and data arrays, read asynchronously. It rewrites the program only while `rstN` is held low. It also assumes that the instruction word seen during the second clock of a control transfer carries no meaning. The bench leaves whatever lies at that address untouched and checks that it has no effect.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int WORD = 16;

  typedef enum logic [2:0] {T_KEEP, T_NOS, T_ALU, T_LIT, T_RTOP, T_MTOP, T_RDATA} tosSel_e;
  typedef enum logic [1:0] {N_KEEP, N_TOS, N_MTOP, N_M2} nosSel_e;
  typedef enum logic [2:0] {M_NONE, M_PUSHNOS, M_PUSHTOS, M_TOPNOS, M_TOPTOS} memOp_e;
  typedef enum logic [1:0] {D_KEEP, D_INC, D_DEC, D_DEC2} dDelta_e;
  typedef enum logic [1:0] {R_NONE, R_PUSHTOS, R_PUSHLIT, R_POP} rOp_e;
  typedef enum logic [2:0] {A_ADD, A_SUB, A_SHL, A_SAR, A_NOT, A_EQ} aluOp_e;

  typedef struct packed {
    tosSel_e          tosSel;
    nosSel_e          nosSel;
    memOp_e           memOp;
    dDelta_e          dDelta;
    rOp_e             rOp;
    aluOp_e           aluOp;
    logic [1:0]       need;
    logic             memWr;
    logic [WORD-1:0]  lit;
  } strobe_t;

  localparam logic [4:0] OP_ADD  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SHL  = 5'd3;
  localparam logic [4:0] OP_SAR  = 5'd4;
  localparam logic [4:0] OP_NOT  = 5'd5;
  localparam logic [4:0] OP_EQ   = 5'd6;
  localparam logic [4:0] OP_DUP  = 5'd7;
  localparam logic [4:0] OP_DROP = 5'd8;
  localparam logic [4:0] OP_SWAP = 5'd9;
  localparam logic [4:0] OP_OVER = 5'd10;
  localparam logic [4:0] OP_NIP  = 5'd11;
  localparam logic [4:0] OP_TUCK = 5'd12;
  localparam logic [4:0] OP_ROT  = 5'd13;
  localparam logic [4:0] OP_MROT = 5'd14;
  localparam logic [4:0] OP_LOAD = 5'd15;
  localparam logic [4:0] OP_STOR = 5'd16;
  localparam logic [4:0] OP_TOR  = 5'd17;
  localparam logic [4:0] OP_FROMR = 5'd18;

  localparam logic [2:0] CL_STACK = 3'd0;
  localparam logic [2:0] CL_JMP   = 3'd1;
  localparam logic [2:0] CL_JZ    = 3'd2;
  localparam logic [2:0] CL_CALL  = 3'd3;
  localparam logic [2:0] CL_RET   = 3'd4;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
(
  input  aluOp_e          op,
  input  logic [WORD-1:0] tos,
  input  logic [WORD-1:0] nos,
  output logic [WORD-1:0] res
);
  logic            isSub;
  logic [WORD-1:0] opB, sum;

  // one adder: subtract = add inverted top with carry-in set
  assign isSub = (op == A_SUB);
  assign opB   = isSub ? ~tos : tos;
  assign sum   = nos + opB + {{(WORD-1){1'b0}}, isSub};

  always_comb begin
    unique case (op)
      A_ADD, A_SUB: res = sum;
      A_SHL:        res = {tos[WORD-2:0], 1'b0};
      A_SAR:        res = {tos[WORD-1], tos[WORD-1:1]};
      A_NOT:        res = ~tos;
      A_EQ:         res = (nos == tos) ? {WORD{1'b1}} : '0;
      default:      res = sum;
    endcase
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [WORD-1:0] instr,
  input  logic [WORD-1:0] tosVal,
  input  logic [AW-1:0]   rTopAddr,
  output strobe_t         strb,
  output logic [AW-1:0]   pc,
  output logic            xferPhase
);
  typedef enum logic {S_RUN, S_XFER} state_e;
  state_e        state;
  logic [AW-1:0] tgt, tgtNext, field, pcInc;
  logic          isCtl;

  assign field     = instr[AW-1:0];
  assign pcInc     = pc + 1'b1;
  assign xferPhase = (state == S_XFER);
  assign isCtl     = !instr[15] && (instr[14:12] inside {CL_JMP, CL_JZ, CL_CALL, CL_RET});

  always_comb begin
    strb    = '0;
    tgtNext = pcInc;
    if (state == S_RUN) begin
      if (instr[15]) begin
        strb.tosSel = T_LIT; strb.nosSel = N_TOS; strb.memOp = M_PUSHNOS;
        strb.dDelta = D_INC; strb.lit = {1'b0, instr[14:0]};
      end else begin
        unique case (instr[14:12])
          CL_JMP:  tgtNext = field;
          CL_JZ: begin
            strb.tosSel = T_NOS; strb.nosSel = N_MTOP; strb.dDelta = D_DEC; strb.need = 2'd1;
            tgtNext = (tosVal == '0) ? field : pcInc;
          end
          CL_CALL: begin
            strb.rOp = R_PUSHLIT; strb.lit = WORD'(pcInc); tgtNext = field;
          end
          CL_RET: begin
            strb.rOp = R_POP; tgtNext = rTopAddr;
          end
          CL_STACK: begin
            unique case (instr[4:0])
              OP_ADD, OP_SUB, OP_EQ: begin
                strb.tosSel = T_ALU; strb.nosSel = N_MTOP; strb.dDelta = D_DEC; strb.need = 2'd2;
                strb.aluOp = (instr[4:0] == OP_ADD) ? A_ADD : (instr[4:0] == OP_SUB) ? A_SUB : A_EQ;
              end
              OP_SHL, OP_SAR, OP_NOT: begin
                strb.tosSel = T_ALU; strb.need = 2'd1;
                strb.aluOp = (instr[4:0] == OP_SHL) ? A_SHL : (instr[4:0] == OP_SAR) ? A_SAR : A_NOT;
              end
              OP_DUP: begin
                strb.nosSel = N_TOS; strb.memOp = M_PUSHNOS; strb.dDelta = D_INC; strb.need = 2'd1;
              end
              OP_DROP: begin
                strb.tosSel = T_NOS; strb.nosSel = N_MTOP; strb.dDelta = D_DEC; strb.need = 2'd1;
              end
              OP_SWAP: begin
                strb.tosSel = T_NOS; strb.nosSel = N_TOS; strb.need = 2'd2;
              end
              OP_OVER: begin
                strb.tosSel = T_NOS; strb.nosSel = N_TOS; strb.memOp = M_PUSHNOS;
                strb.dDelta = D_INC; strb.need = 2'd2;
              end
              OP_NIP: begin
                strb.nosSel = N_MTOP; strb.dDelta = D_DEC; strb.need = 2'd2;
              end
              OP_TUCK: begin
                strb.memOp = M_PUSHTOS; strb.dDelta = D_INC; strb.need = 2'd2;
              end
              OP_ROT: begin
                strb.tosSel = T_MTOP; strb.nosSel = N_TOS; strb.memOp = M_TOPNOS; strb.need = 2'd3;
              end
              OP_MROT: begin
                strb.tosSel = T_NOS; strb.nosSel = N_MTOP; strb.memOp = M_TOPTOS; strb.need = 2'd3;
              end
              OP_LOAD: begin
                strb.tosSel = T_RDATA; strb.need = 2'd1;
              end
              OP_STOR: begin
                strb.tosSel = T_MTOP; strb.nosSel = N_M2; strb.dDelta = D_DEC2;
                strb.need = 2'd2; strb.memWr = 1'b1;
              end
              OP_TOR: begin
                strb.tosSel = T_NOS; strb.nosSel = N_MTOP; strb.dDelta = D_DEC;
                strb.need = 2'd1; strb.rOp = R_PUSHTOS;
              end
              OP_FROMR: begin
                strb.tosSel = T_RTOP; strb.nosSel = N_TOS; strb.memOp = M_PUSHNOS;
                strb.dDelta = D_INC; strb.rOp = R_POP;
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_RUN;
      pc    <= '0;
      tgt   <= '0;
    end else if (state == S_XFER) begin
      state <= S_RUN;
      pc    <= tgt;
    end else if (isCtl) begin
      state <= S_XFER;
      tgt   <= tgtNext;
    end else begin
      pc <= pcInc;
    end
  end
endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int MI = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [WORD-1:0] dataRdata,
  output logic [WORD-1:0] tos,
  output logic [WORD-1:0] nos,
  output logic [WORD-1:0] rTop,
  output logic [DW-1:0]   dDepth,
  output logic [DW-1:0]   rDepth,
  output logic            dataWe,
  output logic            ovfFlag,
  output logic            unfFlag
);
  logic [WORD-1:0] dMem [DEPTH];
  logic [WORD-1:0] rMem [DEPTH];
  logic [WORD-1:0] mTop, m2, aluRes, tosN, nosN, memWVal, rWVal;
  logic [MI-1:0]   memWIdx;
  logic            memW, rPush, rPop, dPush, unfNow, ovfNow, fault;

  stk_alu u_alu (.op(strb.aluOp), .tos(tos), .nos(nos), .res(aluRes));

  assign mTop  = (dDepth >= DW'(3)) ? dMem[MI'(dDepth - DW'(3))] : '0;
  assign m2    = (dDepth >= DW'(4)) ? dMem[MI'(dDepth - DW'(4))] : '0;
  assign rTop  = (rDepth != '0) ? rMem[MI'(rDepth - DW'(1))] : '0;
  assign dPush = (strb.dDelta == D_INC);
  assign rPush = (strb.rOp == R_PUSHTOS) || (strb.rOp == R_PUSHLIT);
  assign rPop  = (strb.rOp == R_POP);

  assign unfNow = (DW'(strb.need) > dDepth) || (rPop && rDepth == '0);
  assign ovfNow = (dPush && dDepth == DW'(DEPTH)) || (rPush && rDepth == DW'(DEPTH));
  assign fault  = unfNow || ovfNow;
  assign dataWe = strb.memWr && !fault;
  assign rWVal  = (strb.rOp == R_PUSHTOS) ? tos : strb.lit;

  always_comb begin
    unique case (strb.tosSel)
      T_NOS:   tosN = nos;
      T_ALU:   tosN = aluRes;
      T_LIT:   tosN = strb.lit;
      T_RTOP:  tosN = rTop;
      T_MTOP:  tosN = mTop;
      T_RDATA: tosN = dataRdata;
      default: tosN = tos;
    endcase
    unique case (strb.nosSel)
      N_TOS:   nosN = tos;
      N_MTOP:  nosN = mTop;
      N_M2:    nosN = m2;
      default: nosN = nos;
    endcase
    memW    = 1'b0;
    memWIdx = MI'(dDepth - DW'(2));
    memWVal = nos;
    unique case (strb.memOp)
      M_PUSHNOS: memW = (dDepth >= DW'(2));
      M_PUSHTOS: begin memW = (dDepth >= DW'(2)); memWVal = tos; end
      M_TOPNOS:  begin memW = 1'b1; memWIdx = MI'(dDepth - DW'(3)); end
      M_TOPTOS:  begin memW = 1'b1; memWIdx = MI'(dDepth - DW'(3)); memWVal = tos; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rstN && !fault && memW) dMem[memWIdx] <= memWVal;
    if (rstN && !fault && rPush) rMem[MI'(rDepth)] <= rWVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tos <= '0; nos <= '0; dDepth <= '0; rDepth <= '0;
      ovfFlag <= 1'b0; unfFlag <= 1'b0;
    end else begin
      ovfFlag <= ovfFlag | ovfNow;
      unfFlag <= unfFlag | unfNow;
      if (!fault) begin
        tos <= tosN;
        nos <= nosN;
        unique case (strb.dDelta)
          D_INC:   dDepth <= dDepth + DW'(1);
          D_DEC:   dDepth <= dDepth - DW'(1);
          D_DEC2:  dDepth <= dDepth - DW'(2);
          default: ;
        endcase
        if (rPush)     rDepth <= rDepth + DW'(1);
        else if (rPop) rDepth <= rDepth - DW'(1);
      end
    end
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW = 12,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [AW-1:0]   progAddr,
  input  logic [WORD-1:0] progData,
  output logic [WORD-1:0] dataAddr,
  output logic [WORD-1:0] dataWdata,
  output logic            dataWe,
  input  logic [WORD-1:0] dataRdata,
  output logic [WORD-1:0] tosOut,
  output logic [WORD-1:0] nosOut,
  output logic [WORD-1:0] rTopOut,
  output logic [DW-1:0]   dDepth,
  output logic [DW-1:0]   rDepth,
  output logic            ovfFlag,
  output logic            unfFlag
);
  strobe_t strb;
  logic    xferPhase;

  stk_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .instr(progData), .tosVal(tosOut),
    .rTopAddr(rTopOut[AW-1:0]), .strb(strb), .pc(progAddr), .xferPhase(xferPhase)
  );

  stk_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .dataRdata(dataRdata),
    .tos(tosOut), .nos(nosOut), .rTop(rTopOut), .dDepth(dDepth), .rDepth(rDepth),
    .dataWe(dataWe), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  assign dataAddr  = tosOut;
  assign dataWdata = nosOut;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int DEPTH = 16,
  parameter int AW = 12,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [AW-1:0] progAddr,
  input logic [15:0]   progData,
  input logic          dataWe,
  input logic [DW-1:0] dDepth,
  input logic [DW-1:0] rDepth,
  input logic          ovfFlag,
  input logic          unfFlag,
  input logic          xferPhase
);
  logic isCtl;
  assign isCtl = !progData[15] && (progData[14:12] inside {3'd1, 3'd2, 3'd3, 3'd4});

  // R13
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!xferPhase && !isCtl) |=> (progAddr == $past(progAddr) + 1'b1));

  // R10
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!xferPhase && isCtl) |=> (xferPhase && $stable(progAddr)));

  // R11
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferPhase |=> !xferPhase);

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);

  // R12
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |=> unfFlag);

  // R12
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dDepth <= DW'(DEPTH)) && (rDepth <= DW'(DEPTH)));

  // R8
  store_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWe |-> !xferPhase);
endmodule

bind stk_core stk_core_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .progAddr(progAddr), .progData(progData), .dataWe(dataWe),
  .dDepth(dDepth), .rDepth(rDepth), .ovfFlag(ovfFlag), .unfFlag(unfFlag),
  .xferPhase(xferPhase)
);

// File: tb/sim_stk_core.sv
module sim_stk_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] progAddr;
  logic [15:0] progData, dataAddr, dataWdata, dataRdata, tosOut, nosOut, rTopOut;
  logic        dataWe, ovfFlag, unfFlag;
  logic [4:0]  dDepth, rDepth;

  logic [15:0] prog [4096];
  logic [15:0] dmem [256];
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign progData  = prog[progAddr];
  assign dataRdata = dmem[dataAddr[7:0]];
  always @(posedge clk) if (dataWe) dmem[dataAddr[7:0]] <= dataWdata;

  stk_core u0 (
    .clk(clk), .rstN(rstN), .progAddr(progAddr), .progData(progData),
    .dataAddr(dataAddr), .dataWdata(dataWdata), .dataWe(dataWe), .dataRdata(dataRdata),
    .tosOut(tosOut), .nosOut(nosOut), .rTopOut(rTopOut), .dDepth(dDepth), .rDepth(rDepth),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  function automatic logic [15:0] lit(input int v);  return {1'b1, 15'(v)};         endfunction
  function automatic logic [15:0] op(input int n);   return {11'd0, 5'(n)};         endfunction
  function automatic logic [15:0] jmp(input int t);  return {4'h1, 12'(t)};         endfunction
  function automatic logic [15:0] jz(input int t);   return {4'h2, 12'(t)};         endfunction
  function automatic logic [15:0] call(input int t); return {4'h3, 12'(t)};         endfunction
  localparam logic [15:0] RET = 16'h4000;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic begin_test();
    rstN = 1'b0;
    for (int i = 0; i < 4096; i++) prog[i] = 16'h0000;
  endtask

  task automatic release_rst();
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    begin_test();
    prog[0] = lit(5);
    @(negedge clk);
    chk("R1 pc in reset", 16'(progAddr), 0);
    chk("R1 we in reset", 16'(dataWe), 0);
    release_rst();
    #1;
    chk("R1 pc", 16'(progAddr), 0);
    chk("R1 depth", 16'(dDepth), 0);
    chk("R1 rdepth", 16'(rDepth), 0);
    chk("R1 tos", tosOut, 0);
    chk("R1 flags", {14'd0, ovfFlag, unfFlag}, 0);
  endtask

  task automatic t_arith();
    begin_test();
    prog[0] = lit(7); prog[1] = lit(3); prog[2] = op(1); prog[3] = lit(20);
    prog[4] = op(2);  prog[5] = op(4);  prog[6] = op(3); prog[7] = op(5);
    release_rst();
    step(2);
    chk("R2 literal", tosOut, 16'd3);
    step(1);
    chk("R3 add", tosOut, 16'd10);
    chk("R3 add depth", 16'(dDepth), 1);
    step(2);
    chk("R3 sub", tosOut, 16'hFFF6);
    step(1);
    chk("R4 sar", tosOut, 16'hFFFB);
    step(1);
    chk("R4 shl", tosOut, 16'hFFF6);
    step(1);
    chk("R4 not", tosOut, 16'h0009);
    chk("R13 pc", 16'(progAddr), 8);
  endtask

  task automatic t_eq();
    begin_test();
    prog[0] = lit(5); prog[1] = lit(5); prog[2] = op(6); prog[3] = lit(4); prog[4] = op(6);
    release_rst();
    step(3);
    chk("R5 equal", tosOut, 16'hFFFF);
    chk("R5 depth", 16'(dDepth), 1);
    step(2);
    chk("R5 unequal", tosOut, 16'h0000);
    chk("R5 depth2", 16'(dDepth), 1);
  endtask

  task automatic t_perm();
    begin_test();
    prog[0] = lit(1); prog[1] = lit(2); prog[2] = lit(3); prog[3] = op(13);
    prog[4] = op(14); prog[5] = op(8);  prog[6] = op(9);  prog[7] = op(10);
    prog[8] = op(11); prog[9] = lit(9); prog[10] = op(12); prog[11] = op(8); prog[12] = op(7);
    release_rst();
    step(4);
    chk("R6 rot tos", tosOut, 1); chk("R6 rot nos", nosOut, 3);
    step(1);
    chk("R6 -rot tos", tosOut, 3); chk("R6 -rot nos", nosOut, 2);
    chk("R6 depth", 16'(dDepth), 3);
    step(1);
    chk("R7 drop tos", tosOut, 2); chk("R7 drop nos", nosOut, 1);
    step(1);
    chk("R7 swap", {tosOut[7:0], nosOut[7:0]}, 16'h0102);
    step(1);
    chk("R7 over", {tosOut[7:0], nosOut[7:0]}, 16'h0201);
    chk("R7 over depth", 16'(dDepth), 3);
    step(1);
    chk("R7 nip", {tosOut[7:0], nosOut[7:0]}, 16'h0202);
    chk("R7 nip depth", 16'(dDepth), 2);
    step(2);
    chk("R6 tuck", {tosOut[7:0], nosOut[7:0]}, 16'h0902);
    chk("R6 tuck depth", 16'(dDepth), 4);
    step(1);
    chk("R6 tuck third", {tosOut[7:0], nosOut[7:0]}, 16'h0209);
    step(1);
    chk("R7 dup", {tosOut[7:0], nosOut[7:0]}, 16'h0202);
    chk("R7 dup depth", 16'(dDepth), 4);
  endtask

  task automatic t_mem();
    begin_test();
    for (int i = 0; i < 256; i++) dmem[i] = 16'h0000;
    dmem[8'h20] = 16'hBEEF;
    prog[0] = lit(16'h55); prog[1] = lit(16'h10); prog[2] = op(16);
    prog[3] = lit(16'h10); prog[4] = op(15); prog[5] = lit(16'h20); prog[6] = op(15);
    release_rst();
    step(2);
    chk("R8 store we", 16'(dataWe), 1);
    chk("R8 store addr", dataAddr, 16'h10);
    chk("R8 store data", dataWdata, 16'h55);
    step(1);
    chk("R8 stored", dmem[8'h10], 16'h55);
    chk("R8 store depth", 16'(dDepth), 0);
    step(2);
    chk("R8 fetch back", tosOut, 16'h55);
    step(2);
    chk("R8 fetch pre", tosOut, 16'hBEEF);
    chk("R8 fetch nos", nosOut, 16'h55);
  endtask

  task automatic t_rstack();
    begin_test();
    prog[0] = lit(16'h77); prog[1] = op(17); prog[2] = op(18);
    release_rst();
    step(2);
    chk("R9 >r rtop", rTopOut, 16'h77);
    chk("R9 >r depths", {3'd0, rDepth, 3'd0, dDepth}, 16'h0100);
    step(1);
    chk("R9 r> tos", tosOut, 16'h77);
    chk("R9 r> depths", {3'd0, rDepth, 3'd0, dDepth}, 16'h0001);
  endtask

  task automatic t_jump();
    begin_test();
    prog[0] = jmp(5); prog[1] = lit(16'h66); prog[5] = lit(16'h11);
    release_rst();
    step(1);
    chk("R10 jmp hold", 16'(progAddr), 0);
    chk("R10 jmp no effect", 16'(dDepth), 0);
    step(1);
    chk("R10 jmp target", 16'(progAddr), 5);
    step(1);
    chk("R10 jmp exec", tosOut, 16'h11);
    chk("R13 after jmp", 16'(progAddr), 6);
  endtask

  task automatic t_jz();
    begin_test();
    prog[0] = lit(0); prog[1] = jz(10); prog[10] = lit(16'h22);
    release_rst();
    step(2);
    chk("R10 jz pop", 16'(dDepth), 0);
    chk("R10 jz hold", 16'(progAddr), 1);
    step(1);
    chk("R10 jz taken", 16'(progAddr), 10);
    begin_test();
    prog[0] = lit(1); prog[1] = jz(10); prog[2] = lit(16'h33);
    release_rst();
    step(3);
    chk("R10 jz not taken", 16'(progAddr), 2);
    chk("R10 jz nt pop", 16'(dDepth), 0);
    step(1);
    chk("R10 jz fallthrough", tosOut, 16'h33);
  endtask

  task automatic t_call();
    begin_test();
    prog[0] = call(8); prog[1] = lit(16'h44); prog[8] = RET;
    release_rst();
    step(1);
    chk("R11 call push", rTopOut, 1);
    chk("R11 call rdepth", 16'(rDepth), 1);
    chk("R11 call hold", 16'(progAddr), 0);
    step(1);
    chk("R11 call target", 16'(progAddr), 8);
    step(1);
    chk("R11 ret pop", 16'(rDepth), 0);
    step(1);
    chk("R11 ret target", 16'(progAddr), 1);
    step(1);
    chk("R11 after ret", tosOut, 16'h44);
  endtask

  task automatic t_under();
    begin_test();
    prog[0] = op(8); prog[1] = lit(3); prog[2] = op(1); prog[3] = op(18);
    release_rst();
    step(1);
    chk("R12 unf set", 16'(unfFlag), 1);
    chk("R12 unf depth", 16'(dDepth), 0);
    step(1);
    chk("R12 unf sticky", {15'd0, unfFlag}, 1);
    chk("R12 push after unf", 16'(dDepth), 1);
    step(1);
    chk("R12 add blocked", tosOut, 3);
    chk("R12 add blocked depth", 16'(dDepth), 1);
    step(1);
    chk("R12 r> blocked", {3'd0, rDepth, 3'd0, dDepth}, 16'h0001);
    chk("R12 no ovf", 16'(ovfFlag), 0);
  endtask

  task automatic t_over();
    begin_test();
    for (int i = 0; i < 16; i++) prog[i] = lit(i + 1);
    prog[16] = lit(99); prog[17] = op(8);
    release_rst();
    step(16);
    chk("R12 full depth", 16'(dDepth), 16);
    chk("R12 full no ovf", 16'(ovfFlag), 0);
    step(1);
    chk("R12 ovf set", 16'(ovfFlag), 1);
    chk("R12 ovf depth", 16'(dDepth), 16);
    chk("R12 ovf tos kept", tosOut, 16);
    step(1);
    chk("R12 deep drop", {tosOut[7:0], nosOut[7:0]}, 16'h0F0E);
    chk("R12 ovf sticky", 16'(ovfFlag), 1);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_eq();
    t_perm();
    t_mem();
    t_rstack();
    t_jump();
    t_jz();
    t_call();
    t_under();
    t_over();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule